// File: doc/BRIEF.md
# Overcurrent Foldback Regulator

This block is the digital heart of a primary-side current limiter for a switching converter. Two comparator flags report whether the sensed primary current sits above a lower trip level (100 mV of sense voltage) or above an upper trip level (150 mV). A small code gives how far the sense voltage stands above the lower level. The block keeps a 12-bit saturating integrator in place of an analog limit capacitor. The integrator charges at a fixed step while current is normal. It discharges in proportion to the excess while current is moderately high. It is forced to a programmable floor at once when current is severe.

From the integrator value the block derives a duty-cycle ceiling for the PWM generator and an oscillator divide ratio. As the integrator falls, the duty ceiling comes down first, until it reaches the minimum duty. Only below a second boundary does the divide ratio rise, one step at a time, up to a limit of 5 (one fifth of nominal frequency). A severe overcurrent also asserts a stop-switching flag. As soon as both flags clear, the outputs return to unrestricted voltage-mode values on the next cycle while the integrator recharges in the background. No soft-start cycle is started on recovery. The interface has no data stream: every pin is a plain control or status level, with no valid/ready handshake and no back-pressure.

Top module: `ilim_foldback`

## Requirements
- R1: After reset the integrator holds full scale (4095), `duty_lim_o` is 255, `fold_div_o` is 1 and `stop_o` is 0.
- R2: In a cycle with both flags low the integrator rises by 16 and saturates at 4095. The next outputs are `duty_lim_o`=255, `fold_div_o`=1 and `stop_o`=0, whatever the integrator value.
- R3: In a cycle with `trip_lo_i`=1 and `trip_hi_i`=0 the integrator falls by 4 times `excess_i`, but not below `cfg_floor_i`. An `excess_i` of 0 holds it.
- R4: In a cycle with `trip_hi_i`=1 the integrator is set to `cfg_floor_i` and `stop_o` is 1 from the next edge, whatever `trip_lo_i` is.
- R5: While limiting (either flag set in the last cycle), an integrator at or above `cfg_duty_knee_i` gives `duty_lim_o`=255 and `fold_div_o`=1.
- R6: While limiting with the integrator above `cfg_fold_knee_i` and below `cfg_duty_knee_i`, `duty_lim_o` = min(255, 16 + (acc − fold_knee)/4) and `fold_div_o`=1.
- R7: While limiting with the integrator at or below `cfg_fold_knee_i`, `duty_lim_o` is the minimum duty 16 and `fold_div_o` = min(5, 1 + (fold_knee − acc)/64). A divide ratio above 1 only ever appears together with minimum duty.
- R8: On the first cycle with both flags low after limiting, the outputs return to unrestricted values at the next edge and `stop_o` clears, with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trip_lo_i | input | 1 | Sense above lower threshold |
| trip_hi_i | input | 1 | Sense above upper threshold |
| excess_i | input | 4 | Sense magnitude above the lower threshold |
| cfg_floor_i | input | 12 | Integrator lower clamp |
| cfg_duty_knee_i | input | 12 | Integrator value below which duty is limited |
| cfg_fold_knee_i | input | 12 | Integrator value at or below which frequency folds back |
| duty_lim_o | output | 8 | Duty-cycle ceiling code |
| fold_div_o | output | 3 | Oscillator divide ratio, 1 to 5 |
| stop_o | output | 1 | Stop switching |

## Verification
A wrong integrator value is hidden while current is normal, because the outputs are then forced to unrestricted values. It shows within one cycle of the next limiting cycle, as a duty ceiling or divide ratio that does not match the expected mapping. An integrator that fails to saturate after a long recharge wraps to a small value. It then shows as minimum duty and deep foldback on the first moderate cycle. A region register that lags or is stuck shows at once on `stop_o`, or as restricted outputs after the flags have cleared. The bench therefore compares all three outputs every cycle against an independent model.

// File: rtl/ilim_pkg.sv
package ilim_pkg;
  typedef enum logic [1:0] {
    RG_NORMAL   = 2'd0,
    RG_MODERATE = 2'd1,
    RG_SEVERE   = 2'd2
  } region_e;
endpackage

// File: rtl/ilim_region.sv
module ilim_region
  import ilim_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    trip_lo_i,
  input  logic    trip_hi_i,
  output region_e region_o
);
  region_e region_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         region_q <= RG_NORMAL;
    else if (trip_hi_i) region_q <= RG_SEVERE;
    else if (trip_lo_i) region_q <= RG_MODERATE;
    else                region_q <= RG_NORMAL;
  end

  assign region_o = region_q;

  a_r4_severe_wins: assert property (@(posedge clk) disable iff (!rst_n)
    trip_hi_i |=> region_q == RG_SEVERE);
endmodule

// File: rtl/ilim_integrator.sv
module ilim_integrator #(
  parameter int AW        = 12,
  parameter int XW        = 4,
  parameter int CHG_STEP  = 16,
  parameter int DIS_SHIFT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trip_lo_i,
  input  logic          trip_hi_i,
  input  logic [XW-1:0] excess_i,
  input  logic [AW-1:0] floor_i,
  output logic [AW-1:0] acc_o
);
  localparam logic [AW-1:0] ACC_MAX = '1;

  logic [AW-1:0] acc_q;
  logic [AW:0]   dec;
  logic [AW:0]   rise;
  logic [AW:0]   low_bound;
  logic [AW-1:0] acc_d;

  always_comb begin
    dec       = (AW+1)'(excess_i) << DIS_SHIFT;
    rise      = {1'b0, acc_q} + (AW+1)'(CHG_STEP);
    low_bound = {1'b0, floor_i} + dec;
    if (trip_hi_i)
      acc_d = floor_i;
    else if (trip_lo_i)
      acc_d = ({1'b0, acc_q} <= low_bound) ? floor_i : AW'({1'b0, acc_q} - dec);
    else
      acc_d = (rise > {1'b0, ACC_MAX}) ? ACC_MAX : rise[AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) acc_q <= ACC_MAX;
    else        acc_q <= acc_d;
  end

  assign acc_o = acc_q;

  a_r2_charge_up: assert property (@(posedge clk) disable iff (!rst_n)
    (!trip_lo_i && !trip_hi_i && acc_q != ACC_MAX) |=> acc_q > $past(acc_q));
  a_r3_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_lo_i && !trip_hi_i) |=> acc_q <= $past(acc_q) || acc_q == $past(floor_i));
  a_r4_to_floor: assert property (@(posedge clk) disable iff (!rst_n)
    trip_hi_i |=> acc_q == $past(floor_i));
endmodule

// File: rtl/ilim_shaper.sv
module ilim_shaper
  import ilim_pkg::*;
#(
  parameter int AW         = 12,
  parameter int DW         = 8,
  parameter int DIVW       = 3,
  parameter int DUTY_MIN   = 16,
  parameter int DUTY_SHIFT = 2,
  parameter int FOLD_SHIFT = 6,
  parameter int DIV_MAX    = 5
) (
  input  region_e         region_i,
  input  logic [AW-1:0]   acc_i,
  input  logic [AW-1:0]   duty_knee_i,
  input  logic [AW-1:0]   fold_knee_i,
  output logic [DW-1:0]   duty_o,
  output logic [DIVW-1:0] div_o,
  output logic            stop_o
);
  localparam logic [DW-1:0]   DUTY_FULL = '1;
  localparam logic [DIVW-1:0] DIV_ONE   = DIVW'(1);

  logic [AW-1:0] above_fold;
  logic [AW-1:0] below_fold;
  logic [AW:0]   duty_sum;
  logic [AW-1:0] steps;

  always_comb begin
    above_fold = acc_i - fold_knee_i;
    below_fold = fold_knee_i - acc_i;
    duty_sum   = (AW+1)'(above_fold >> DUTY_SHIFT) + (AW+1)'(DUTY_MIN);
    steps      = below_fold >> FOLD_SHIFT;
    duty_o     = DUTY_FULL;
    div_o      = DIV_ONE;
    if (region_i != RG_NORMAL) begin
      if (acc_i >= duty_knee_i) begin
        duty_o = DUTY_FULL;
      end else if (acc_i > fold_knee_i) begin
        duty_o = (duty_sum >= (AW+1)'(DUTY_FULL)) ? DUTY_FULL : duty_sum[DW-1:0];
      end else begin
        duty_o = DW'(DUTY_MIN);
        div_o  = (steps >= AW'(DIV_MAX - 1)) ? DIVW'(DIV_MAX)
                                              : DIV_ONE + steps[DIVW-1:0];
      end
    end
    stop_o = (region_i == RG_SEVERE);
  end
endmodule

// File: rtl/ilim_foldback.sv
module ilim_foldback
  import ilim_pkg::*;
#(
  parameter int AW         = 12,
  parameter int DW         = 8,
  parameter int XW         = 4,
  parameter int DIVW       = 3,
  parameter int CHG_STEP   = 16,
  parameter int DIS_SHIFT  = 2,
  parameter int DUTY_MIN   = 16,
  parameter int DUTY_SHIFT = 2,
  parameter int FOLD_SHIFT = 6,
  parameter int DIV_MAX    = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trip_lo_i,
  input  logic            trip_hi_i,
  input  logic [XW-1:0]   excess_i,
  input  logic [AW-1:0]   cfg_floor_i,
  input  logic [AW-1:0]   cfg_duty_knee_i,
  input  logic [AW-1:0]   cfg_fold_knee_i,
  output logic [DW-1:0]   duty_lim_o,
  output logic [DIVW-1:0] fold_div_o,
  output logic            stop_o
);
  localparam logic [DW-1:0] DUTY_FULL = '1;

  region_e       region;
  logic [AW-1:0] acc;

  ilim_region u_region (
    .clk      (clk),
    .rst_n    (rst_n),
    .trip_lo_i(trip_lo_i),
    .trip_hi_i(trip_hi_i),
    .region_o (region)
  );

  ilim_integrator #(
    .AW(AW), .XW(XW), .CHG_STEP(CHG_STEP), .DIS_SHIFT(DIS_SHIFT)
  ) u_integ (
    .clk      (clk),
    .rst_n    (rst_n),
    .trip_lo_i(trip_lo_i),
    .trip_hi_i(trip_hi_i),
    .excess_i (excess_i),
    .floor_i  (cfg_floor_i),
    .acc_o    (acc)
  );

  ilim_shaper #(
    .AW(AW), .DW(DW), .DIVW(DIVW), .DUTY_MIN(DUTY_MIN),
    .DUTY_SHIFT(DUTY_SHIFT), .FOLD_SHIFT(FOLD_SHIFT), .DIV_MAX(DIV_MAX)
  ) u_shaper (
    .region_i   (region),
    .acc_i      (acc),
    .duty_knee_i(cfg_duty_knee_i),
    .fold_knee_i(cfg_fold_knee_i),
    .duty_o     (duty_lim_o),
    .div_o      (fold_div_o),
    .stop_o     (stop_o)
  );

  a_r4_stop_next: assert property (@(posedge clk) disable iff (!rst_n)
    trip_hi_i |=> stop_o);
  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!trip_lo_i && !trip_hi_i) |=> (duty_lim_o == DUTY_FULL && fold_div_o == DIVW'(1) && !stop_o));
  a_r7_fold_after_min: assert property (@(posedge clk) disable iff (!rst_n)
    (fold_div_o != DIVW'(1)) |-> (duty_lim_o == DW'(DUTY_MIN)));
  a_r7_div_range: assert property (@(posedge clk) disable iff (!rst_n)
    (fold_div_o >= DIVW'(1)) && (fold_div_o <= DIVW'(DIV_MAX)));
endmodule

// File: tb/ilim_foldback_tb.sv
module ilim_foldback_tb;
  localparam int CLK_PERIOD = 10;
  localparam int FLOOR = 64;
  localparam int DKNEE = 2048;
  localparam int FKNEE = 1024;

  typedef struct {
    int    duty;
    int    div;
    int    stop;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       trip_lo = 1'b0;
  logic       trip_hi = 1'b0;
  logic [3:0] excess = '0;
  logic [7:0] duty;
  logic [2:0] fdiv;
  logic       stop;

  int   checks = 0;
  int   fails = 0;
  int   m_acc = 4095;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ilim_foldback u_dut (
    .clk(clk), .rst_n(rst_n),
    .trip_lo_i(trip_lo), .trip_hi_i(trip_hi), .excess_i(excess),
    .cfg_floor_i(12'(FLOOR)), .cfg_duty_knee_i(12'(DKNEE)), .cfg_fold_knee_i(12'(FKNEE)),
    .duty_lim_o(duty), .fold_div_o(fdiv), .stop_o(stop)
  );

  task automatic step(input logic lo, input logic hi, input int ex);
    exp_t e;
    int   s;
    @(negedge clk);
    trip_lo = lo; trip_hi = hi; excess = 4'(ex);
    if (hi) begin
      m_acc = FLOOR;
    end else if (lo) begin
      m_acc = (m_acc - ex*4 < FLOOR) ? FLOOR : m_acc - ex*4;
    end else begin
      m_acc = (m_acc + 16 > 4095) ? 4095 : m_acc + 16;
    end
    e.stop = hi ? 1 : 0;
    if (!lo && !hi) begin
      e.duty = 255; e.div = 1; e.tag = "R2 R8 normal";
    end else if (m_acc >= DKNEE) begin
      e.duty = 255; e.div = 1; e.tag = hi ? "R4 R5 severe" : "R3 R5 moderate";
    end else if (m_acc > FKNEE) begin
      e.duty = 16 + (m_acc - FKNEE) / 4;
      if (e.duty > 255) e.duty = 255;
      e.div = 1; e.tag = hi ? "R4 R6 severe" : "R3 R6 moderate";
    end else begin
      s = (FKNEE - m_acc) / 64;
      e.duty = 16; e.div = (s >= 4) ? 5 : 1 + s;
      e.tag = hi ? "R4 R7 severe" : "R3 R7 moderate";
    end
    q.push_back(e);
  endtask

  task automatic run(input int n, input logic lo, input logic hi, input int ex);
    for (int i = 0; i < n; i++) step(lo, hi, ex);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (duty != 8'(e.duty) || fdiv != 3'(e.div) || stop != e.stop[0]) begin
          fails++;
          $display("FAIL %s: duty=%0d div=%0d stop=%0d expected duty=%0d div=%0d stop=%0d",
                   e.tag, duty, fdiv, stop, e.duty, e.div, e.stop);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (duty != 8'd255 || fdiv != 3'd1 || stop != 1'b0) begin
      fails++;
      $display("FAIL R1 reset: duty=%0d div=%0d stop=%0d expected duty=255 div=1 stop=0",
               duty, fdiv, stop);
    end
    run(10, 1'b0, 1'b0, 0);    // R2 saturated charge
    run(70, 1'b1, 1'b0, 15);   // R3 R5 R6 R7 steep discharge through both knees
    run(5,  1'b1, 1'b0, 0);    // R3 zero excess holds
    run(3,  1'b0, 1'b0, 0);    // R8 immediate release
    run(40, 1'b1, 1'b0, 7);    // R3 slower discharge
    run(2,  1'b0, 1'b1, 0);    // R4 severe
    run(1,  1'b0, 1'b0, 0);    // R8 stop clears
    run(1,  1'b1, 1'b1, 15);   // R4 upper flag dominates
    run(3,  1'b1, 1'b0, 3);    // R3 floor clamp
    run(300, 1'b0, 1'b0, 0);   // R2 recharge to saturation
    run(12, 1'b1, 1'b0, 15);   // R5 saturated start of discharge
    @(negedge clk);
    trip_lo = 1'b0; trip_hi = 1'b0;
    repeat (2) @(negedge clk);
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule